// File: doc/BRIEF.md
# I/Q Serial Output Frame Port

This block turns parallel I/Q sample pairs into a serial frame on one data line. Each frame carries one I word followed by one Q word, most significant bit first. A frame-sync output and an end-of-frame flag travel with the data. A host that counts bits can rely on the frame sync alone. A host that cannot count bits watches the end-of-frame flag to learn that the frame has finished.

Four static configuration inputs control the port: a word-length code, a frame-sync style, a master/slave select and a serial clock divider. As master, the port makes the serial clock from the core clock and issues frame sync itself. As slave, it synchronises an external serial clock and frame sync into the core clock domain, and a frame starts when frame sync is seen high at a rising serial-clock edge. Samples arrive through a valid/ready handshake into a single holding register. That register accepts a pair only while the port is idle and empty, so a sender with a pair must keep it valid until the running frame has ended.

All outputs are registers in the core clock domain. They change only in the core cycle that follows a rising serial-clock edge (in master mode, the same core edge at which the serial clock goes high). The host can therefore sample on the falling edge or on the next rising edge.

Top module: `iq_serial_tx`

## Requirements
- R1: The word-length code sets the bits per word: 00 gives 12 bits, 01 gives 16 bits, and 10 or 11 gives 24 bits. Both words of a frame use the same length.
- R2: Each frame first has a sync slot, in which data is 0. The I word follows, then the Q word, each sent most significant bit first, one bit per serial-clock period. A word shorter than the 24-bit sample keeps the sample's upper bits.
- R3: With frame-sync style 00 in master mode, frame sync is high for exactly the one serial-clock period of the sync slot. The first I bit appears at the next rising edge, where frame sync falls.
- R4: With frame-sync style 01 in master mode, frame sync stays high from the sync slot through the last Q bit and falls at the rising edge after it.
- R5: With frame-sync style 10 or 11 in master mode, one gap slot is inserted between the I and Q words. In the gap slot, frame sync is high for one serial-clock period and data is 0. Frame sync is low during all data bits.
- R6: In master mode the serial clock has a 50% duty cycle. Each half period lasts N core cycles for a divider value N from 1 to 15, and 1 core cycle for the value 0.
- R7: In master mode, data, frame sync and end-of-frame change only at a core edge where the serial clock rises.
- R8: End-of-frame is high for exactly the one serial-clock period in which the last Q bit is on the data line, and it is low otherwise.
- R9: In slave mode, the serial clock output and frame sync output stay low. A frame starts at a rising edge of the external serial clock where the external frame sync is high, and a pair is held. The first I bit follows at the next rising edge. The Q word follows the I word with no gap slot in every frame-sync style.
- R10: Ready is high only while the port is idle and holds no pair. A pair is taken when valid and ready are both high. Changes on the sample inputs after acceptance do not alter the frame that carries the accepted pair.
- R11: After reset, data, frame sync, end-of-frame and the serial clock output are low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wlen | input | 2 | Word-length code (R1) |
| cfg_fs_mode | input | 2 | Frame-sync style (R3, R4, R5) |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_div | input | DIV_W | Serial clock divider (R6) |
| in_valid | input | 1 | Sample pair valid |
| in_ready | output | 1 | Port can accept a pair |
| in_i | input | SAMPLE_W | I sample |
| in_q | input | SAMPLE_W | Q sample |
| sclk_in | input | 1 | External serial clock (slave) |
| fs_in | input | 1 | External frame sync (slave) |
| sclk_out | output | 1 | Generated serial clock (master) |
| fs_out | output | 1 | Frame sync output (master) |
| sdo | output | 1 | Serial data |
| eof | output | 1 | End-of-frame flag |

## Verification
Five rules are checked on every cycle: the half-period length of the generated serial clock, the rule that outputs move only with a rising serial clock in master mode, the single-period end-of-frame, the quiet serial clock and frame-sync outputs in slave mode, and the rule that ready is never high while a frame is being sent. The content of a frame is shown only by the bench's scenarios. That content is the bit order, the truncation for each word length, the frame-sync shape of each style, the gap slot, and the slave start on an external frame sync. The bench's scenarios also show that a pair offered during a frame waits and then appears intact in the next frame.

// File: rtl/sofp_pkg.sv
package sofp_pkg;

   localparam int WORD_MAX = 24;
   localparam int BITS_W   = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SYNC,
      ST_IWORD,
      ST_GAP,
      ST_QWORD
   } frm_state_t;

   function automatic logic [BITS_W-1:0] word_bits(input logic [1:0] sel);
      logic [BITS_W-1:0] n;
      case (sel)
         2'b00:   n = 5'd12;
         2'b01:   n = 5'd16;
         default: n = 5'd24;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/sofp_clock_gen.sv
module sofp_clock_gen #(
   parameter int DIV_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master,
   input  logic [DIV_W-1:0] div,
   input  logic             sclk_in,
   input  logic             fs_in,
   output logic             sclk_out,
   output logic             rise_tick,
   output logic             fs_seen
);

   logic [DIV_W-1:0] half;
   logic [DIV_W-1:0] cnt;
   logic             sclk_q;
   logic             wrap;
   logic             m_rise;
   logic             s_rise;
   logic [SYNC_STAGES:0]   s_sclk;
   logic [SYNC_STAGES-1:0] s_fs;

   assign half   = (div == '0) ? DIV_W'(1) : div;
   assign wrap   = (cnt >= half - DIV_W'(1));
   assign m_rise = master && wrap && !sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sclk_q <= 1'b0;
      end else if (!master) begin
         cnt    <= '0;
         sclk_q <= 1'b0;
      end else if (wrap) begin
         cnt    <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt    <= cnt + DIV_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_sclk[0] <= 1'b0;
         s_fs[0]   <= 1'b0;
      end else begin
         s_sclk[0] <= sclk_in;
         s_fs[0]   <= fs_in;
      end
   end

   for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sclk_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_sclk[g] <= 1'b0;
         else        s_sclk[g] <= s_sclk[g-1];
      end
   end

   for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_fs_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_fs[g] <= 1'b0;
         else        s_fs[g] <= s_fs[g-1];
      end
   end

   assign s_rise    = s_sclk[SYNC_STAGES-1] && !s_sclk[SYNC_STAGES];
   assign rise_tick = master ? m_rise : s_rise;
   assign fs_seen   = s_fs[SYNC_STAGES-1];
   assign sclk_out  = sclk_q;

endmodule

// File: rtl/sofp_sample_hold.sv
module sofp_sample_hold #(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_i,
   input  logic [SAMPLE_W-1:0] in_q,
   input  logic                idle,
   input  logic                take,
   output logic                in_ready,
   output logic                pend,
   output logic [SAMPLE_W-1:0] hold_i,
   output logic [SAMPLE_W-1:0] hold_q
);

   logic accept;

   assign in_ready = idle && !pend;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         hold_i <= '0;
         hold_q <= '0;
      end else if (accept) begin
         pend   <= 1'b1;
         hold_i <= in_i;
         hold_q <= in_q;
      end else if (take) begin
         pend   <= 1'b0;
      end
   end

endmodule

// File: rtl/sofp_frame_engine.sv
module sofp_frame_engine
   import sofp_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rise,
   input  logic                master,
   input  logic                fs_seen,
   input  logic [1:0]          wlen,
   input  logic [1:0]          fs_mode,
   input  logic                pend,
   input  logic [SAMPLE_W-1:0] hold_i,
   input  logic [SAMPLE_W-1:0] hold_q,
   output logic                take,
   output logic                idle,
   output logic                sdo,
   output logic                fs_out,
   output logic                eof
);

   frm_state_t          st;
   logic [WORD_MAX-1:0] ish;
   logic [WORD_MAX-1:0] qsh;
   logic [BITS_W-1:0]   bitcnt;
   logic [BITS_W-1:0]   wl_q;
   logic [1:0]          mode_q;
   logic                master_q;
   logic                hold_fs;
   logic                split_fs;

   assign idle     = (st == ST_IDLE);
   assign take     = rise && idle && pend && (master || fs_seen);
   assign hold_fs  = master_q && (mode_q == 2'b01);
   assign split_fs = master_q && mode_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ish      <= '0;
         qsh      <= '0;
         bitcnt   <= '0;
         wl_q     <= '0;
         mode_q   <= '0;
         master_q <= 1'b0;
         sdo      <= 1'b0;
         fs_out   <= 1'b0;
         eof      <= 1'b0;
      end else if (rise) begin
         case (st)
            ST_IDLE: begin
               if (take) begin
                  ish      <= hold_i[SAMPLE_W-1 -: WORD_MAX];
                  qsh      <= hold_q[SAMPLE_W-1 -: WORD_MAX];
                  wl_q     <= word_bits(wlen);
                  mode_q   <= fs_mode;
                  master_q <= master;
                  fs_out   <= master;
                  sdo      <= 1'b0;
                  st       <= ST_SYNC;
               end
            end
            ST_SYNC: begin
               sdo    <= ish[WORD_MAX-1];
               ish    <= ish << 1;
               bitcnt <= wl_q - BITS_W'(1);
               fs_out <= hold_fs;
               st     <= ST_IWORD;
            end
            ST_IWORD: begin
               if (bitcnt != '0) begin
                  sdo    <= ish[WORD_MAX-1];
                  ish    <= ish << 1;
                  bitcnt <= bitcnt - BITS_W'(1);
               end else if (split_fs) begin
                  sdo    <= 1'b0;
                  fs_out <= 1'b1;
                  st     <= ST_GAP;
               end else begin
                  sdo    <= qsh[WORD_MAX-1];
                  qsh    <= qsh << 1;
                  bitcnt <= wl_q - BITS_W'(1);
                  st     <= ST_QWORD;
               end
            end
            ST_GAP: begin
               sdo    <= qsh[WORD_MAX-1];
               qsh    <= qsh << 1;
               bitcnt <= wl_q - BITS_W'(1);
               fs_out <= 1'b0;
               st     <= ST_QWORD;
            end
            ST_QWORD: begin
               if (bitcnt != '0) begin
                  sdo    <= qsh[WORD_MAX-1];
                  qsh    <= qsh << 1;
                  bitcnt <= bitcnt - BITS_W'(1);
                  eof    <= (bitcnt == BITS_W'(1));
               end else begin
                  sdo    <= 1'b0;
                  fs_out <= 1'b0;
                  eof    <= 1'b0;
                  st     <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/iq_serial_tx.sv
module iq_serial_tx #(
   parameter int SAMPLE_W    = 24,
   parameter int DIV_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_wlen,
   input  logic [1:0]          cfg_fs_mode,
   input  logic                cfg_master,
   input  logic [DIV_W-1:0]    cfg_div,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_i,
   input  logic [SAMPLE_W-1:0] in_q,
   input  logic                sclk_in,
   input  logic                fs_in,
   output logic                sclk_out,
   output logic                fs_out,
   output logic                sdo,
   output logic                eof
);

   if (SAMPLE_W < sofp_pkg::WORD_MAX) begin : g_bad_sample_w
      $error("SAMPLE_W must be at least the longest word length");
   end
   if (DIV_W < 1) begin : g_bad_div_w
      $error("DIV_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                rise_tick;
   logic                fs_seen;
   logic                take;
   logic                idle;
   logic                pend;
   logic [SAMPLE_W-1:0] hold_i;
   logic [SAMPLE_W-1:0] hold_q;

   sofp_clock_gen #(
      .DIV_W       (DIV_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_clock_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .master    (cfg_master),
      .div       (cfg_div),
      .sclk_in   (sclk_in),
      .fs_in     (fs_in),
      .sclk_out  (sclk_out),
      .rise_tick (rise_tick),
      .fs_seen   (fs_seen)
   );

   sofp_sample_hold #(
      .SAMPLE_W (SAMPLE_W)
   ) u_sample_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_i     (in_i),
      .in_q     (in_q),
      .idle     (idle),
      .take     (take),
      .in_ready (in_ready),
      .pend     (pend),
      .hold_i   (hold_i),
      .hold_q   (hold_q)
   );

   sofp_frame_engine #(
      .SAMPLE_W (SAMPLE_W)
   ) u_frame_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise_tick),
      .master  (cfg_master),
      .fs_seen (fs_seen),
      .wlen    (cfg_wlen),
      .fs_mode (cfg_fs_mode),
      .pend    (pend),
      .hold_i  (hold_i),
      .hold_q  (hold_q),
      .take    (take),
      .idle    (idle),
      .sdo     (sdo),
      .fs_out  (fs_out),
      .eof     (eof)
   );

endmodule

// File: rtl/sofp_checks.sv
module sofp_checks #(
   parameter int DIV_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_master,
   input logic [DIV_W-1:0] cfg_div,
   input logic             in_ready,
   input logic             sclk_out,
   input logic             fs_out,
   input logic             sdo,
   input logic             eof
);

   logic [7:0]       run_len;
   logic             prev_s;
   logic             prev_master;
   logic [DIV_W-1:0] prev_div;
   logic             armed;
   logic [7:0]       want_half;

   assign want_half = (cfg_div == '0) ? 8'd1 : 8'(cfg_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len     <= '0;
         prev_s      <= 1'b0;
         prev_master <= 1'b0;
         prev_div    <= '0;
         armed       <= 1'b0;
      end else begin
         if (cfg_div != prev_div || cfg_master != prev_master) begin
            armed   <= 1'b0;
            run_len <= '0;
         end else if (sclk_out != prev_s) begin
            if (armed && cfg_master) begin
               p_half_period_r6: assert (run_len + 8'd1 == want_half);
            end
            armed   <= 1'b1;
            run_len <= '0;
         end else begin
            run_len <= run_len + 8'd1;
         end
         prev_s      <= sclk_out;
         prev_master <= cfg_master;
         prev_div    <= cfg_div;
      end
   end

   p_edge_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && $past(cfg_master) && !$rose(sclk_out))
      |-> ($stable(sdo) && $stable(fs_out) && $stable(eof)));

   p_eof_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && $rose(sclk_out) && $past(eof)) |-> !eof);

   p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_master && !$past(cfg_master)) |-> (!sclk_out && !fs_out));

   p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!fs_out && !eof && !sdo));

endmodule

bind iq_serial_tx sofp_checks #(.DIV_W(DIV_W)) u_sofp_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_master (cfg_master),
   .cfg_div    (cfg_div),
   .in_ready   (in_ready),
   .sclk_out   (sclk_out),
   .fs_out     (fs_out),
   .sdo        (sdo),
   .eof        (eof)
);

// File: tb/iq_serial_tx_bench.sv
`timescale 1ns/1ps
module iq_serial_tx_bench;

   localparam int SW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_wlen = 2'b00;
   logic [1:0]    cfg_fs_mode = 2'b00;
   logic          cfg_master = 1'b1;
   logic [3:0]    cfg_div = 4'd3;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [SW-1:0] in_i = '0;
   logic [SW-1:0] in_q = '0;
   logic          sclk_in = 1'b0;
   logic          fs_in = 1'b0;
   logic          sclk_out;
   logic          fs_out;
   logic          sdo;
   logic          eof;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   logic [2:0] got [0:63];
   int  rec_n = 0;
   bit  rec_en = 0;
   bit  started = 0;
   int  off_edge = 0;
   logic prev_sclk = 0, prev_sdo = 0, prev_fs = 0, prev_eof = 0;

   always #2.5 clk = ~clk;

   iq_serial_tx u_iq_serial_tx (
      .clk(clk), .rst_n(rst_n), .cfg_wlen(cfg_wlen), .cfg_fs_mode(cfg_fs_mode),
      .cfg_master(cfg_master), .cfg_div(cfg_div), .in_valid(in_valid),
      .in_ready(in_ready), .in_i(in_i), .in_q(in_q), .sclk_in(sclk_in),
      .fs_in(fs_in), .sclk_out(sclk_out), .fs_out(fs_out), .sdo(sdo), .eof(eof)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000 && !done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rec_en && cfg_master) begin
         if (sclk_out && !prev_sclk) begin
            if (!started && fs_out) begin
               started = 1;
               got[0]  = {sdo, fs_out, eof};
               rec_n   = 1;
            end else if (started && rec_n < 64) begin
               got[rec_n] = {sdo, fs_out, eof};
               rec_n++;
            end
         end else if (started && (sdo != prev_sdo || fs_out != prev_fs || eof != prev_eof)) begin
            off_edge++;
         end
      end
      prev_sclk = sclk_out;
      prev_sdo  = sdo;
      prev_fs   = fs_out;
      prev_eof  = eof;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int wl_of(input logic [1:0] sel);
      return (sel == 2'b00) ? 12 : (sel == 2'b01) ? 16 : 24;
   endfunction

   task automatic send_pair(input logic [SW-1:0] vi, input logic [SW-1:0] vq);
      int guard = 0;
      @(negedge clk);
      in_valid = 1'b1;
      in_i = vi;
      in_q = vq;
      while (!in_ready && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic check_frame(input string req, input logic [1:0] wsel, input logic [1:0] mode,
                              input bit master, input logic [SW-1:0] vi, input logic [SW-1:0] vq);
      logic [2:0] exp [0:63];
      int n = 0;
      int wl = wl_of(wsel);
      bit hold = master && (mode == 2'b01);
      exp[n++] = {1'b0, master, 1'b0};
      for (int k = 0; k < wl; k++) exp[n++] = {vi[SW-1-k], hold, 1'b0};
      if (master && mode[1]) exp[n++] = 3'b010;
      for (int k = 0; k < wl; k++) exp[n++] = {vq[SW-1-k], hold, (k == wl-1)};
      exp[n++] = 3'b000;
      check(req, "slot count", rec_n, n);
      for (int s = 0; s < n && s < rec_n; s++)
         check(req, $sformatf("slot %0d {sdo,fs,eof}", s), int'(got[s]), int'(exp[s]));
   endtask

   function automatic int frame_len(input logic [1:0] wsel, input logic [1:0] mode, input bit master);
      return 2 + 2 * wl_of(wsel) + ((master && mode[1]) ? 1 : 0);
   endfunction

   task automatic wait_slots(input int n);
      int guard = 0;
      while (rec_n < n && guard < 20000) begin
         @(negedge clk);
         #1;
         guard++;
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", "sdo after reset", sdo, 0);
      check("R11", "fs_out after reset", fs_out, 0);
      check("R11", "eof after reset", eof, 0);
      check("R11", "sclk_out after reset", sclk_out, 0);
      check("R11", "in_ready after reset", in_ready, 1);
   endtask

   task automatic t_divider(input logic [3:0] d);
      int hi = 0, lo = 0, guard = 0;
      int half = (d == 0) ? 1 : d;
      cfg_master = 1'b1;
      cfg_div = d;
      repeat (40) @(negedge clk);
      while (!(sclk_out && !prev_sclk) && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      while (sclk_out && guard < 2000) begin hi++; @(negedge clk); guard++; end
      while (!sclk_out && guard < 3000) begin lo++; @(negedge clk); guard++; end
      check("R6", $sformatf("high half, div %0d", d), hi, half);
      check("R6", $sformatf("low half, div %0d", d), lo, half);
   endtask

   task automatic t_master(input string req, input logic [1:0] wsel, input logic [1:0] mode,
                           input logic [3:0] d, input logic [SW-1:0] vi, input logic [SW-1:0] vq);
      cfg_master = 1'b1;
      cfg_div = d;
      cfg_wlen = wsel;
      cfg_fs_mode = mode;
      repeat (40) @(negedge clk);
      rec_n = 0;
      started = 0;
      off_edge = 0;
      rec_en = 1;
      send_pair(vi, vq);
      wait_slots(frame_len(wsel, mode, 1));
      rec_en = 0;
      check_frame(req, wsel, mode, 1, vi, vq);
      check("R7", "output changes away from a rising serial clock", off_edge, 0);
   endtask

   task automatic t_handshake;
      logic [SW-1:0] ai = 24'hE1_7B_3D, aq = 24'h0F_55_A2;
      logic [SW-1:0] bi = 24'h5A_C6_19, bq = 24'hB2_08_FE;
      int ready_bad = 0;
      int n = frame_len(2'b00, 2'b00, 1);
      int guard = 0;
      cfg_master = 1'b1;
      cfg_div = 4'd4;
      cfg_wlen = 2'b00;
      cfg_fs_mode = 2'b00;
      repeat (40) @(negedge clk);
      rec_n = 0;
      started = 0;
      rec_en = 1;
      send_pair(ai, aq);
      in_valid = 1'b1;
      in_i = bi;
      in_q = bq;
      while (rec_n < n && guard < 20000) begin
         @(negedge clk);
         #1;
         if (rec_n < n && in_ready) ready_bad++;
         guard++;
      end
      check_frame("R10 first pair", 2'b00, 2'b00, 1, ai, aq);
      rec_n = 0;
      started = 0;
      check("R10", "ready cycles during busy frame", ready_bad, 0);
      guard = 0;
      while (!in_ready && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_i = '0;
      in_q = '0;
      wait_slots(n);
      rec_en = 0;
      check_frame("R10 held pair", 2'b00, 2'b00, 1, bi, bq);
   endtask

   task automatic sclk_period;
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
      sclk_in = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_slave(input logic [1:0] wsel, input logic [1:0] mode,
                          input logic [SW-1:0] vi, input logic [SW-1:0] vq);
      int n = frame_len(wsel, mode, 0);
      int sclk_bad = 0;
      cfg_master = 1'b0;
      cfg_wlen = wsel;
      cfg_fs_mode = mode;
      sclk_in = 1'b0;
      fs_in = 1'b0;
      repeat (20) @(negedge clk);
      send_pair(vi, vq);
      repeat (2) sclk_period();
      check("R9", "no frame without external frame sync", sdo | eof, 0);
      fs_in = 1'b1;
      repeat (8) @(negedge clk);
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
      sclk_in = 1'b0;
      fs_in = 1'b0;
      repeat (8) @(negedge clk);
      got[0] = {sdo, fs_out, eof};
      rec_n = 1;
      for (int s = 1; s < n; s++) begin
         sclk_period();
         got[s] = {sdo, fs_out, eof};
         if (sclk_out) sclk_bad++;
         rec_n++;
      end
      check_frame("R9 slave frame", wsel, mode, 0, vi, vq);
      check("R9", "sclk_out high in slave mode", sclk_bad, 0);
   endtask

   initial begin
      t_reset();
      t_divider(4'd0);
      t_divider(4'd3);
      t_divider(4'd7);
      t_master("R1 R2 R3 R8 12-bit single pulse", 2'b00, 2'b00, 4'd2, 24'hC3_A5_5A, 24'h3C_F0_0F);
      t_master("R1 R2 R4 R8 16-bit held sync", 2'b01, 2'b01, 4'd1, 24'h96_E2_47, 24'h1B_7D_C8);
      t_master("R1 R2 R5 R8 24-bit split sync", 2'b10, 2'b10, 4'd3, 24'hA7_33_C1, 24'h6E_0B_95);
      t_master("R1 R5 code 11 fastest clock", 2'b11, 2'b11, 4'd0, 24'h81_FF_01, 24'h7E_00_FE);
      t_handshake();
      t_slave(2'b01, 2'b10, 24'hD4_29_6B, 24'h35_9C_E0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule